// File: doc/BRIEF.md
# Digital Soft-Start Sequencer with Pre-Bias Gating

This block produces the reference code for a buck converter's error amplifier during start-up. After a start pulse, the code climbs from zero to full scale one step at a time, and every step lasts a fixed number of clock cycles. With the default 6-bit code the ramp has 64 levels. Software cannot change the step length. It is set only by a parameter at build time, and a typical choice gives a ramp of about 13.6 ms.

The block also decides when the power switches may start switching. Two comparator flags come in from outside. One says the output voltage is above the present ramp level. The other says the output is above the final target.

- If the output starts below target, switching is held off until the ramp passes the output level. The loop then continues regulating from there.
- If the output starts above target, switching is held off until the ramp ends.

In both cases a pre-charged output is not pulled down early. Once switching is enabled, it stays enabled until reset or until a new start pulse arrives. A completion flag rises when the code reaches full scale.

Top module: `soft_start_ctrl`

## Requirements
- R1: While reset is active, and right after it is released, the outputs are: `ref_code_o` = 0, `sw_en_o` = 0, `done_o` = 0.
- R2: After the clock edge that samples `start_i` high, `ref_code_o` goes up by exactly one every `STEP_CYCLES` cycles. Code k is output from edge k*`STEP_CYCLES` after the start edge.
- R3: `ref_code_o` never exceeds full scale, 2^`CODE_W`-1. `done_o` rises on the same edge on which the code reaches full scale. After that, both the code and `done_o` hold until the next start.
- R4: With both comparator flags low during the ramp, `sw_en_o` rises one cycle after the start edge.
- R5: While `out_above_final_i` is low and `out_above_ramp_i` is high, `sw_en_o` stays low. It rises on the first edge that samples `out_above_ramp_i` low during the ramp.
- R6: While `out_above_final_i` is high, `sw_en_o` stays low during the ramp. It rises together with `done_o`, whatever `out_above_ramp_i` does.
- R7: Once `sw_en_o` is high, it stays high whatever the flags do, until reset or the next start pulse.
- R8: A start pulse during the ramp returns the code to 0 and clears `sw_en_o` and `done_o` on the next edge. The ramp then runs again with the timing given in R2.
- R9: A start pulse after the ramp has finished restarts it in the same way as R8.
- R10: Before the first start pulse, the comparator flags have no effect: `sw_en_o` and `ref_code_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart pulse from the sequencer |
| out_above_ramp_i | input | 1 | Output voltage is above the present ramp level |
| out_above_final_i | input | 1 | Output voltage is above the final target |
| ref_code_o | output | CODE_W | Reference code for the DAC |
| sw_en_o | output | 1 | Power switches may switch |
| done_o | output | 1 | Ramp has reached full scale |

## Verification
The bench keeps the default `CODE_W` of 6 but shortens `STEP_CYCLES` to 2. This makes the whole 64-level ramp only 126 cycles long, so every table row can run the ramp from zero all the way to completion. The bench models the ramp comparator from the code itself, using a pre-bias threshold set per row. With these values, thresholds at zero, mid-ramp, the last code and beyond full scale all stay short enough to check both the exact edge on which switching is enabled and the exact edge on which `done_o` rises.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RAMP = 2'd1,
    SS_DONE = 2'd2
  } ss_state_e;
endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
  parameter int STEP_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen
  import ss_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  output logic [CODE_W-1:0] code_o,
  output logic              running_o,
  output logic              last_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  ss_state_e         state_q;
  logic [CODE_W-1:0] code_q;

  // final step completes on this edge
  assign last_o = !start_i && (state_q == SS_RAMP) && tick_i && (code_q == FULL - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SS_IDLE;
      code_q  <= '0;
    end else if (start_i) begin
      state_q <= SS_RAMP;
      code_q  <= '0;
    end else if (state_q == SS_RAMP && tick_i) begin
      code_q <= code_q + 1'b1;
      if (last_o) state_q <= SS_DONE;
    end
  end

  assign code_o    = code_q;
  assign running_o = (state_q == SS_RAMP);
  assign done_o    = (state_q == SS_DONE);
endmodule

// File: rtl/ss_sw_gate.sv
module ss_sw_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic running_i,
  input  logic last_i,
  input  logic above_ramp_i,
  input  logic above_final_i,
  output logic sw_en_o
);
  logic sw_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_en_q <= 1'b0;
    end else if (start_i) begin
      sw_en_q <= 1'b0;
    end else if (last_i) begin
      sw_en_q <= 1'b1;                        // end of ramp releases any hold-off
    end else if (running_i && !above_final_i && !above_ramp_i) begin
      sw_en_q <= 1'b1;                        // ramp has caught the output
    end
  end

  assign sw_en_o = sw_en_q;
endmodule

// File: rtl/soft_start_ctrl.sv
module soft_start_ctrl #(
  parameter int CODE_W      = 6,
  parameter int STEP_CYCLES = 10600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              out_above_ramp_i,
  input  logic              out_above_final_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              sw_en_o,
  output logic              done_o
);
  logic tick, running, last;

  ss_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .run_i  (running),
    .tick_o (tick)
  );

  ss_ramp_gen #(.CODE_W(CODE_W)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tick_i    (tick),
    .code_o    (ref_code_o),
    .running_o (running),
    .last_o    (last),
    .done_o    (done_o)
  );

  ss_sw_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .running_i     (running),
    .last_i        (last),
    .above_ramp_i  (out_above_ramp_i),
    .above_final_i (out_above_final_i),
    .sw_en_o       (sw_en_o)
  );
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              out_above_ramp_i,
  input logic              out_above_final_i,
  input logic [CODE_W-1:0] ref_code_o,
  input logic              sw_en_o,
  input logic              done_o
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  p_start_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ref_code_o == '0) && !sw_en_o && !done_o);

  p_unit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (ref_code_o == $past(ref_code_o)) ||
                 (ref_code_o == CODE_W'($past(ref_code_o) + 1'b1)));

  p_done_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ref_code_o == FULL);

  p_done_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o && !start_i |=> sw_en_o);

  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) && !done_o |-> $past(!out_above_ramp_i && !out_above_final_i));

  p_hold_final_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_o && !done_o && out_above_final_i && !start_i |=> !sw_en_o || done_o);
endmodule

bind soft_start_ctrl ss_checker #(.CODE_W(CODE_W)) u_ss_checker (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .start_i           (start_i),
  .out_above_ramp_i  (out_above_ramp_i),
  .out_above_final_i (out_above_final_i),
  .ref_code_o        (ref_code_o),
  .sw_en_o           (sw_en_o),
  .done_o            (done_o)
);

// File: tb/soft_start_ctrl_bench.sv
module soft_start_ctrl_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int CODE_W      = 6;
  localparam int STEP_CYCLES = 2;
  localparam int FULL        = (1 << CODE_W) - 1;
  localparam int DONE_T      = FULL * STEP_CYCLES;
  localparam int NVEC        = 7;
  // {above_final, ramp threshold code}
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b0, 7'd0}, {1'b0, 7'd10}, {1'b0, 7'd1}, {1'b0, 7'd63},
    {1'b0, 7'd64}, {1'b1, 7'd5}, {1'b1, 7'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic fin_q = 1'b0, force_rmp = 1'b0, force_fin = 1'b0;
  logic [6:0] thr = 7'd0;
  logic above_ramp, above_final, sw_en, done;
  logic [CODE_W-1:0] code;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: output held at the threshold code level
  assign above_ramp  = force_rmp | ({1'b0, code} < thr);
  assign above_final = force_fin | fin_q;

  soft_start_ctrl #(.CODE_W(CODE_W), .STEP_CYCLES(STEP_CYCLES)) u_soft_start_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .out_above_ramp_i(above_ramp), .out_above_final_i(above_final),
    .ref_code_o(code), .sw_en_o(sw_en), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  function automatic int exp_rise(input bit f, input int th);
    int r;
    if (f) return DONE_T;
    r = th * STEP_CYCLES + 1;
    return (r > DONE_T) ? DONE_T : r;
  endfunction

  task automatic run_row(input bit f, input int th);
    int rise = -1, bad = 0, bad_act = 0, bad_exp = 0, ec;
    string lbl;
    fin_q = f;
    thr = 7'(th);
    pulse_start();
    for (int t = 0; t <= DONE_T + 3; t++) begin
      if (sw_en && rise < 0) rise = t;
      ec = t / STEP_CYCLES;
      if (ec > FULL) ec = FULL;
      if (int'(code) != ec && bad == 0) begin
        bad = 1; bad_act = int'(code); bad_exp = ec;
      end
      if (t == DONE_T - 1) chk(!done, "R3 done early", done, 0);
      if (t == DONE_T) chk(done && int'(code) == FULL, "R3 done at full scale", int'(code), FULL);
      @(negedge clk);
    end
    chk(bad == 0, "R2 code trajectory", bad_act, bad_exp);
    lbl = f ? "R6 switch enable time" : (th == 0 ? "R4 switch enable time" : "R5 switch enable time");
    chk(rise == exp_rise(f, th), lbl, rise, exp_rise(f, th));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(code == '0 && !sw_en && !done, "R1 in reset", {sw_en, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code == '0 && !sw_en && !done, "R1 after release", {sw_en, done}, 0);

    // R10: flags low in idle
    repeat (5) @(negedge clk);
    chk(!sw_en && code == '0, "R10 idle flags ignored", sw_en, 0);

    for (int i = 0; i < NVEC; i++) run_row(VEC[i][7], int'(VEC[i][6:0]));

    // R3: hold after completion
    repeat (10) @(negedge clk);
    chk(done && int'(code) == FULL, "R3 hold at full scale", int'(code), FULL);

    // R9: restart after done
    fin_q = 1'b0; thr = 7'd0;
    pulse_start();
    chk(code == '0 && !done, "R9 restart after done", int'(code), 0);

    // R7: sticky enable
    pulse_start();
    @(negedge clk);
    chk(sw_en, "R7 enable set", sw_en, 1);
    force_rmp = 1'b1; force_fin = 1'b1;
    repeat (8) @(negedge clk);
    chk(sw_en, "R7 enable sticky", sw_en, 1);
    force_rmp = 1'b0; force_fin = 1'b0;

    // R8: restart mid-ramp
    repeat (12) @(negedge clk);
    chk(int'(code) == 10, "R8 mid-ramp code", int'(code), 10);
    fin_q = 1'b1;
    pulse_start();
    chk(code == '0 && !sw_en && !done, "R8 restart clears", int'(code), 0);
    repeat (10) @(negedge clk);
    chk(int'(code) == 10 / STEP_CYCLES && !sw_en, "R8 ramp reruns", int'(code), 10 / STEP_CYCLES);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule